// File: doc/BRIEF.md
# Event Timer Channel Comparator with Persistent Interrupt Status

This block is one channel of a high-precision event timer. It compares a free-running main counter against a target value. On a match it updates a sticky interrupt status flag and delivers the interrupt in one of two ways:

- on a pin, as a held level or a one-cycle pulse;
- as a one-cycle 32-bit message write.

The comparator keeps working while delivery is off, so the status flag records events that happened while the channel or the whole timer was disabled. Turning the channel on, turning the timer on, or changing the trigger type re-evaluates the pin from that retained status.

The surrounding register decoder presents each configuration write as a strobe with the full new value. Inside the block the previous value stays visible for that cycle. Transition rules that depend on the old settings use it. Everything else uses the effective setting for that cycle, which is the written value when a write is present and the held value otherwise. In periodic mode the target advances by the period after each match. A 32-bit mode restricts the target, the period and the comparison to their low 32 bits.

Top module: `evtc_channel`

## Requirements
- R1: After synchronous reset, `status`, `irq` and `msg_valid` are 0. The target is all ones, the period is 0 and all configuration bits are 0.
- R2: A match in level mode sets `status` on the next edge regardless of `chan enable` and `glob_en`; `irq` is not raised unless both are 1.
- R3: With level mode, both enables 1 and pin routing, a match raises `irq` on the next edge and it stays high until the status is cleared or delivery is withdrawn.
- R4: A match in edge mode leaves `status` at 0. It produces a one-cycle `irq` pulse only when both enables are 1.
- R5: A cycle with `clr_wr`=1 and `clr_bit`=1 clears `status` and lowers a level `irq`. `clr_bit`=0 changes nothing. A match in the same cycle takes precedence and sets the flag again.
- R6: A configuration write that changes the trigger from level (`cfg_level`=1) to edge (`cfg_level`=0) clears `status`. If the old setting routed to the pin, it lowers `irq`, even when the same write enables message routing.
- R7: A write that turns `cfg_enable` from 0 to 1 while `status` is set, in level mode with `glob_en`=1, raises `irq` on the next edge.
- R8: When `glob_en` rises, an enabled level channel with `status` set raises `irq`, or issues a message if message routing is on.
- R9: A write that turns `cfg_enable` from 1 to 0 lowers `irq` and keeps `status` unchanged.
- R10: With `cfg_msg`=1, an interrupt event produces a one-cycle `msg_valid` with `msg_addr`=`route[63:32]` and `msg_data`=`route[31:0]`. `irq` holds its value.
- R11: With `cfg_mode32`=1, the stored target and period keep only bits [31:0], and matching compares only bits [31:0] of `count`.
- R12: With `cfg_periodic`=1, a match adds the period to the target; with `cfg_periodic`=0 the target is not reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count | input | CNT_W | Main counter value |
| glob_en | input | 1 | Global timer enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | New channel interrupt enable |
| cfg_level | input | 1 | New trigger type, 1 = level, 0 = edge |
| cfg_mode32 | input | 1 | New 32-bit mode |
| cfg_msg | input | 1 | New message-routing enable |
| cfg_periodic | input | 1 | New periodic mode |
| tgt_load | input | 1 | Load target and period |
| tgt_value | input | CNT_W | Target value to load |
| tgt_period | input | CNT_W | Period value to load |
| route | input | 2*MSG_W | Message address (upper half) and data (lower half) |
| clr_wr | input | 1 | Status write strobe |
| clr_bit | input | 1 | Status write value, 1 clears |
| irq | output | 1 | Interrupt pin |
| msg_valid | output | 1 | One-cycle message-write request |
| msg_addr | output | MSG_W | Message address |
| msg_data | output | MSG_W | Message data |
| status | output | 1 | Sticky interrupt status |

## Verification
The first matches are driven with the channel disabled and then with the timer disabled. The pin stays low while the flag is set, which separates status recording from delivery. Enabling the channel or the timer afterwards, clearing with both write values, and a level-to-edge switch that also enables messaging each show whether the retained flag is re-evaluated or discarded. Periodic edge pulses, a one-shot match and message routing distinguish the reload behaviour from the pin-versus-message choice. A counter and target with differing upper bits separate 32-bit matching from full-width matching.

// File: rtl/evtc_pkg.sv
package evtc_pkg;

    localparam int NARROW_W = 32;

    typedef struct packed {
        logic enable;
        logic level;
        logic mode32;
        logic msg;
        logic periodic;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        PIN_DRIVE = 2'd0,
        PIN_HOLD  = 2'd1,
        PIN_LOW   = 2'd2
    } pin_act_t;

    function automatic pin_act_t pick_pin(input logic lvl2edge,
                                          input chan_cfg_t old_c,
                                          input chan_cfg_t eff_c);
        if (lvl2edge && !old_c.msg) return PIN_LOW;
        else if (eff_c.msg)         return PIN_HOLD;
        else                        return PIN_DRIVE;
    endfunction

endpackage

// File: rtl/evtc_compare.sv
module evtc_compare
    import evtc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cmp,
    input  logic [CNT_W-1:0] load_per,
    input  logic             mode32,
    input  logic             periodic,
    output logic             hit
);
    localparam int HI_W = CNT_W - NARROW_W;

    logic [CNT_W-1:0] cmp_q, per_q, cmp_n, per_n;
    logic             m32_q;

    function automatic logic [CNT_W-1:0] narrow(input logic en, input logic [CNT_W-1:0] v);
        return en ? {{HI_W{1'b0}}, v[NARROW_W-1:0]} : v;
    endfunction

    assign hit = mode32 ? (count[NARROW_W-1:0] == cmp_q[NARROW_W-1:0])
                        : (count == cmp_q);

    always_comb begin
        cmp_n = cmp_q;
        per_n = per_q;
        if (load) begin
            cmp_n = load_cmp;
            per_n = load_per;
        end else if (hit && periodic) begin
            cmp_n = cmp_q + per_q;
        end
        cmp_n = narrow(mode32, cmp_n);
        per_n = narrow(mode32, per_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            per_q <= '0;
            m32_q <= 1'b0;
        end else begin
            cmp_q <= cmp_n;
            per_q <= per_n;
            m32_q <= mode32;
        end
    end

    // R11: in 32-bit mode no upper target or period bits survive
    assert_narrow_R11: assert property (@(posedge clk) disable iff (rst)
        m32_q |-> (cmp_q[CNT_W-1:NARROW_W] == '0 && per_q[CNT_W-1:NARROW_W] == '0));

    // R12: one-shot match leaves the target untouched
    assert_oneshot_R12: assert property (@(posedge clk) disable iff (rst)
        (hit && !periodic && !load && (mode32 == m32_q)) |=> $stable(cmp_q));

endmodule

// File: rtl/evtc_status.sv
module evtc_status
    import evtc_pkg::*;
#(
    parameter int MSG_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    input  logic               cfg_wr,
    input  chan_cfg_t          old_cfg,
    input  chan_cfg_t          eff_cfg,
    input  logic               glob_en,
    input  logic               clr_req,
    input  logic [2*MSG_W-1:0] route,
    output logic               irq,
    output logic               msg_valid,
    output logic [MSG_W-1:0]   msg_addr,
    output logic [MSG_W-1:0]   msg_data,
    output logic               status
);
    logic     status_q, status_n;
    logic     irq_q, irq_n;
    logic     glob_q;
    logic     mv_q, fire;
    logic [MSG_W-1:0] ma_q, md_q;
    logic     active, lvl2edge, en_rise, en_fall, glob_rise;
    pin_act_t act;

    assign active    = eff_cfg.enable && glob_en;
    assign lvl2edge  = cfg_wr && old_cfg.level && !eff_cfg.level;
    assign en_rise   = cfg_wr && !old_cfg.enable && eff_cfg.enable;
    assign en_fall   = cfg_wr && old_cfg.enable && !eff_cfg.enable;
    assign glob_rise = glob_en && !glob_q;
    assign act       = pick_pin(lvl2edge, old_cfg, eff_cfg);

    always_comb begin
        if (lvl2edge)     status_n = 1'b0;
        else if (hit)     status_n = eff_cfg.level;
        else if (clr_req) status_n = 1'b0;
        else              status_n = status_q;
    end

    always_comb begin
        unique case (act)
            PIN_LOW:  irq_n = 1'b0;
            PIN_HOLD: irq_n = irq_q;
            default:  irq_n = active && (eff_cfg.level ? status_n : hit);
        endcase
    end

    assign fire = eff_cfg.msg && active &&
                  (hit || (eff_cfg.level && status_q && (en_rise || glob_rise)));

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
            irq_q    <= 1'b0;
            glob_q   <= 1'b0;
            mv_q     <= 1'b0;
            ma_q     <= '0;
            md_q     <= '0;
        end else begin
            status_q <= status_n;
            irq_q    <= irq_n;
            glob_q   <= glob_en;
            mv_q     <= fire;
            if (fire) begin
                ma_q <= route[2*MSG_W-1:MSG_W];
                md_q <= route[MSG_W-1:0];
            end
        end
    end

    assign irq       = irq_q;
    assign status    = status_q;
    assign msg_valid = mv_q;
    assign msg_addr  = ma_q;
    assign msg_data  = md_q;

    // R2: level match records status whatever the enables
    assert_level_set_R2: assert property (@(posedge clk) disable iff (rst)
        (hit && eff_cfg.level) |=> status_q);

    // R4: edge match never leaves status set
    assert_edge_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (hit && !eff_cfg.level) |=> !status_q);

    // R5: clear without a competing match empties status
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !hit) |=> !status_q);

    // R6: level-to-edge with old pin routing lowers the pin
    assert_l2e_pin_R6: assert property (@(posedge clk) disable iff (rst)
        (lvl2edge && !old_cfg.msg) |=> !irq_q);

    // R7: enabling with retained status raises a level pin
    assert_enable_raise_R7: assert property (@(posedge clk) disable iff (rst)
        (en_rise && status_q && eff_cfg.level && glob_en && !eff_cfg.msg && !clr_req) |=> irq_q);

    // R9: disabling the channel drops the pin on pin routing
    assert_disable_low_R9: assert property (@(posedge clk) disable iff (rst)
        (en_fall && !eff_cfg.msg) |=> !irq_q);

    // R10: message routing leaves the pin as it was
    assert_msg_pin_R10: assert property (@(posedge clk) disable iff (rst)
        (eff_cfg.msg && !lvl2edge) |=> $stable(irq_q));

endmodule

// File: rtl/evtc_channel.sv
module evtc_channel
    import evtc_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int MSG_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   count,
    input  logic               glob_en,
    input  logic               cfg_wr,
    input  logic               cfg_enable,
    input  logic               cfg_level,
    input  logic               cfg_mode32,
    input  logic               cfg_msg,
    input  logic               cfg_periodic,
    input  logic               tgt_load,
    input  logic [CNT_W-1:0]   tgt_value,
    input  logic [CNT_W-1:0]   tgt_period,
    input  logic [2*MSG_W-1:0] route,
    input  logic               clr_wr,
    input  logic               clr_bit,
    output logic               irq,
    output logic               msg_valid,
    output logic [MSG_W-1:0]   msg_addr,
    output logic [MSG_W-1:0]   msg_data,
    output logic               status
);
    chan_cfg_t cfg_q, cfg_in, cfg_eff;
    logic      hit;

    assign cfg_in  = '{enable: cfg_enable, level: cfg_level, mode32: cfg_mode32,
                       msg: cfg_msg, periodic: cfg_periodic};
    assign cfg_eff = cfg_wr ? cfg_in : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_eff;
    end

    evtc_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .count    (count),
        .load     (tgt_load),
        .load_cmp (tgt_value),
        .load_per (tgt_period),
        .mode32   (cfg_eff.mode32),
        .periodic (cfg_eff.periodic),
        .hit      (hit)
    );

    evtc_status #(.MSG_W(MSG_W)) u_sts (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .cfg_wr    (cfg_wr),
        .old_cfg   (cfg_q),
        .eff_cfg   (cfg_eff),
        .glob_en   (glob_en),
        .clr_req   (clr_wr && clr_bit),
        .route     (route),
        .irq       (irq),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .status    (status)
    );

endmodule

// File: tb/evtc_channel_test.sv
`timescale 1ns/1ps
module evtc_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cnt = '0;
    logic        glob = 1'b0;
    logic        cfg_wr = 1'b0, c_en = 1'b0, c_lv = 1'b0, c_32 = 1'b0, c_msg = 1'b0, c_per = 1'b0;
    logic        tgt_load = 1'b0;
    logic [63:0] tgt_value = '0, tgt_period = '0;
    logic [63:0] route = 64'hA5A5_0001_DEAD_BEEF;
    logic        clr_wr = 1'b0, clr_bit = 1'b0;
    logic        irq, msg_valid, status;
    logic [31:0] msg_addr, msg_data;

    int    tests = 0, fails = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    evtc_channel uut (
        .clk(clk), .rst(rst), .count(cnt), .glob_en(glob),
        .cfg_wr(cfg_wr), .cfg_enable(c_en), .cfg_level(c_lv), .cfg_mode32(c_32),
        .cfg_msg(c_msg), .cfg_periodic(c_per),
        .tgt_load(tgt_load), .tgt_value(tgt_value), .tgt_period(tgt_period),
        .route(route), .clr_wr(clr_wr), .clr_bit(clr_bit),
        .irq(irq), .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
        .status(status)
    );

    // behavioural reference
    logic [63:0] m_cmp, m_per;
    logic m_en, m_lv, m_32, m_msg, m_per_mode, m_gq;
    logic m_st, m_irq, m_mv;
    logic [31:0] m_ma, m_md;
    logic e_en, e_lv, e_32, e_msg, e_per, hit_m, on, l2e, wake, st_prev;

    always @(posedge clk) begin
        if (rst) begin
            m_cmp = '1; m_per = '0;
            m_en = 0; m_lv = 0; m_32 = 0; m_msg = 0; m_per_mode = 0; m_gq = 0;
            m_st = 0; m_irq = 0; m_mv = 0; m_ma = '0; m_md = '0;
        end else begin
            e_en  = cfg_wr ? c_en  : m_en;
            e_lv  = cfg_wr ? c_lv  : m_lv;
            e_32  = cfg_wr ? c_32  : m_32;
            e_msg = cfg_wr ? c_msg : m_msg;
            e_per = cfg_wr ? c_per : m_per_mode;
            hit_m = e_32 ? (cnt[31:0] == m_cmp[31:0]) : (cnt == m_cmp);
            on    = e_en && glob;
            l2e   = cfg_wr && m_lv && !c_lv;
            wake  = (cfg_wr && !m_en && c_en) || (glob && !m_gq);
            st_prev = m_st;
            if (l2e)                  m_st = 0;
            else if (hit_m)           m_st = e_lv;
            else if (clr_wr && clr_bit) m_st = 0;
            if (l2e && !m_msg)        m_irq = 0;
            else if (!e_msg)          m_irq = on && (e_lv ? m_st : hit_m);
            m_mv = e_msg && on && (hit_m || (e_lv && st_prev && wake));
            if (m_mv) begin m_ma = route[63:32]; m_md = route[31:0]; end
            if (tgt_load) begin m_cmp = tgt_value; m_per = tgt_period; end
            else if (hit_m && e_per) m_cmp = m_cmp + m_per;
            if (e_32) begin m_cmp[63:32] = '0; m_per[63:32] = '0; end
            m_en = e_en; m_lv = e_lv; m_32 = e_32; m_msg = e_msg; m_per_mode = e_per;
            m_gq = glob;
        end
    end

    task automatic check(string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at t=%0t: actual %0h expected %0h", tag, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check("irq", {63'd0, irq}, {63'd0, m_irq});
        check("status", {63'd0, status}, {63'd0, m_st});
        check("msg_valid", {63'd0, msg_valid}, {63'd0, m_mv});
        if (m_mv) begin
            check("msg_addr", {32'd0, msg_addr}, {32'd0, m_ma});
            check("msg_data", {32'd0, msg_data}, {32'd0, m_md});
        end
    end

    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt = cnt + 1;
            cfg_wr = 0; tgt_load = 0; clr_wr = 0;
        end
    endtask

    task automatic wcfg(logic en, logic lv, logic m32, logic msg, logic per);
        cfg_wr = 1; c_en = en; c_lv = lv; c_32 = m32; c_msg = msg; c_per = per;
    endtask

    task automatic ld(logic [63:0] v, logic [63:0] p);
        tgt_load = 1; tgt_value = v; tgt_period = p;
    endtask

    initial begin
        tag = "R1"; cyc(3); rst = 0; cyc(2);
        // R1 reset state explicitly
        check("R1 reset status", {63'd0, status}, 64'd0);
        check("R1 reset irq", {63'd0, irq}, 64'd0);

        tag = "R2"; cyc(); wcfg(0, 1, 0, 0, 0); glob = 1; ld(cnt + 6, 0); cyc(10);
        check("R2 status kept with pin low", {62'd0, status, irq}, 64'd2);
        tag = "R7"; wcfg(1, 1, 0, 0, 0); cyc(3);
        check("R7 pin raised", {63'd0, irq}, 64'd1);
        tag = "R5"; clr_wr = 1; clr_bit = 0; cyc(2);
        check("R5 zero write ignored", {62'd0, status, irq}, 64'd3);
        clr_wr = 1; clr_bit = 1; cyc(3);
        check("R5 cleared", {62'd0, status, irq}, 64'd0);
        tag = "R3"; ld(cnt + 4, 0); cyc(8);
        check("R3 level held", {62'd0, status, irq}, 64'd3);
        tag = "R9"; wcfg(0, 1, 0, 0, 0); cyc(3);
        check("R9 pin low status kept", {62'd0, status, irq}, 64'd2);
        tag = "R8"; glob = 0; cyc(); wcfg(1, 1, 0, 0, 0); cyc(2);
        check("R8 no pin while global off", {63'd0, irq}, 64'd0);
        glob = 1; cyc(3);
        check("R8 pin after global on", {63'd0, irq}, 64'd1);
        tag = "R6"; wcfg(1, 0, 0, 1, 0); cyc(3);
        check("R6 cleared and lowered", {62'd0, status, irq}, 64'd0);
        wcfg(1, 0, 0, 0, 0); cyc();
        tag = "R4"; wcfg(1, 0, 0, 0, 1); ld(cnt + 3, 4); cyc(14);
        glob = 0; cyc(8); glob = 1; cyc(2);
        tag = "R12"; wcfg(1, 1, 0, 0, 0); ld(cnt + 2, 0); cyc(10);
        clr_wr = 1; clr_bit = 1; cyc(2);
        tag = "R10"; wcfg(1, 1, 0, 1, 1); ld(cnt + 3, 5); cyc(12);
        wcfg(1, 0, 0, 1, 1); cyc(12);
        wcfg(0, 1, 0, 1, 1); ld(cnt + 2, 0); cyc(4);
        route = 64'h1234_5678_0BAD_F00D; wcfg(1, 1, 0, 1, 0); cyc(3);
        tag = "R11"; wcfg(1, 0, 1, 0, 1); cyc();
        cnt = 64'h5_0000_0000;
        ld(64'hFFFF_0000_0000_0010, 64'h7_0000_0003); cyc(40);
        tag = "R11"; wcfg(1, 1, 1, 0, 0); ld(64'h9_0000_0000 + cnt[31:0] + 4, 0); cyc(8);
        check("R11 low-half match", {63'd0, status}, 64'd1);
        cyc(2);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule